// File: doc/BRIEF.md
# DMA Address and Beat Sequencer

This block drives one side of a DMA channel, either the read side or the write side, through a single cell transfer. It is given a start address, a cell length in bytes and a 3-bit address-sequence mode. It then issues a series of bus commands over a valid/ready handshake. Each command carries an address, a beat size and a burst length. A burst is a run of equal-size beats, counted from that address; in the fixed word mode every beat of the burst uses the same address.

There are three fixed-address modes and three incrementing modes. The automatic mode breaks an unaligned region into the largest naturally aligned beats. When the start address, the cell length and the block length are all multiples of the interface width, the automatic mode instead issues full-width bursts. The running address is kept from one cell to the next, so a block can be moved as a chain of cells, with each cell started by a trigger. A misaligned configuration ends the cell at once, issues no command and sets a sticky error flag.

Top module: `dma_beat_seq`

## Requirements
- R1: After reset, cmdValid, cellDone, busy and alignErr are all 0.
- R2: Mode 0 is fixed-address byte. Every command has size code 0, the address stays at the loaded address whatever its alignment, and the burst length is 0. Size codes are 0 = byte, 1 = half word, 2 = word, 3 = double word.
- R3: Mode 1 is fixed half word (size code 1) and mode 2 is fixed word (size code 2). Mode 4 needs the same alignment as mode 1. A cell is rejected when its base address or its length is not a multiple of the beat size for modes 1, 2 and 4, and also for the unused codes 6 and 7. A rejected cell sets alignErr, pulses cellDone on the next cycle and issues no command.
- R4: In mode 2, each command covers min(4, words remaining) beats. cmdBurstLen is that beat count minus 1, and every command keeps the same address.
- R5: Mode 3 (incrementing byte) and mode 4 (incrementing half word) issue single beats of size code 0 and 1. After each beat the address advances by 1 or 2.
- R6: In mode 5 (automatic), without a burst, each beat takes the largest power-of-two size that meets three limits: it is aligned at the current address, it is no more than the bytes left, and it is no wider than the interface. The address then advances by that size. On a 32-bit interface, 8 bytes from 0x1 give byte@0x1, half@0x2, word@0x4, byte@0x8.
- R7: In mode 5, when the base address, the cell length and the block length are all multiples of the interface width, each command is full width with min(4, beats remaining) beats. The address then advances by beats times the width.
- R8: The running address is kept across cells. addrLoad replaces it, and when addrLoad and cellStart come in the same cycle the cell uses the newly loaded address.
- R9: While cmdValid is high and cmdReady is low, cmdValid, cmdAddr, cmdSize and cmdBurstLen hold steady.
- R10: cellDone is high for exactly the cycle after the last command of a cell is accepted. A cell of zero bytes pulses cellDone on the cycle after cellStart and issues no command.
- R11: addrLoad and cellStart have no effect while busy.
- R12: alignErr, once set, stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addrLoad | input | 1 | Load startAddr into the running address (idle only) |
| startAddr | input | ADDR_W | Address to load |
| cellStart | input | 1 | Begin a cell (idle only) |
| seqMode | input | 3 | Address-sequence mode, 0 to 5 |
| cellBytes | input | SIZE_W | Cell length in bytes |
| blockBytes | input | SIZE_W | Block length in bytes, used only for burst eligibility in mode 5 |
| cmdValid | output | 1 | Command available |
| cmdReady | input | 1 | Command accepted when high together with cmdValid |
| cmdAddr | output | ADDR_W | Command start address |
| cmdSize | output | 2 | Beat size code |
| cmdBurstLen | output | 2 | Beats in command minus 1 |
| cellDone | output | 1 | One-cycle end-of-cell pulse |
| busy | output | 1 | A cell is in progress |
| alignErr | output | 1 | Sticky misalignment flag |

## Verification
A new address load and a cell start can land in the same idle cycle. In that case the alignment check, the burst-eligibility decision and the first command must all use the address being loaded, not the address held before. The bench drives both strobes on the same edge for most table rows and compares each command's address with the loaded value. It also loads a misaligned address together with a start and expects a rejection, which can only be judged against the new address. A second collision is tested too: a load and a start arrive in the middle of a cell while a command is stalled. There the expected addresses continue the running sequence unchanged.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [2:0] {
    MODE_FIX_B    = 3'd0,
    MODE_FIX_H    = 3'd1,
    MODE_FIX_W    = 3'd2,
    MODE_INC_B    = 3'd3,
    MODE_INC_H    = 3'd4,
    MODE_INC_AUTO = 3'd5
  } seqMode_e;

  localparam logic [1:0] SZ_BYTE  = 2'd0;
  localparam logic [1:0] SZ_HALF  = 2'd1;
  localparam logic [1:0] SZ_WORD  = 2'd2;

  localparam int MAX_BURST = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic loadAddr;
    logic startCell;
    logic advance;
  } seqStrobe_t;

endpackage

// File: rtl/dma_seq_plan.sv
module dma_seq_plan
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 16,
  parameter int BUS_BYTES = 4
) (
  input  logic [ADDR_W-1:0] curAddr,
  input  logic [SIZE_W-1:0] remBytes,
  input  logic [2:0]        modeQ,
  input  logic              burstOk,
  output logic [1:0]        sizeCode,
  output logic [1:0]        burstLen,
  output logic [SIZE_W-1:0] stepBytes
);
  localparam int BUS_LOG = $clog2(BUS_BYTES);

  logic [SIZE_W-1:0] unitsAvail;
  logic [2:0]        beats;
  logic              useBurst;
  int                unitShift;

  always_comb begin
    sizeCode  = SZ_BYTE;
    useBurst  = 1'b0;
    unitShift = 0;
    case (modeQ)
      MODE_FIX_B, MODE_INC_B: sizeCode = SZ_BYTE;
      MODE_FIX_H, MODE_INC_H: sizeCode = SZ_HALF;
      MODE_FIX_W: begin
        sizeCode  = SZ_WORD;
        useBurst  = 1'b1;
        unitShift = 2;
      end
      MODE_INC_AUTO: begin
        if (burstOk) begin
          sizeCode  = 2'(BUS_LOG);
          useBurst  = 1'b1;
          unitShift = BUS_LOG;
        end else begin
          for (int s = 0; s <= BUS_LOG; s++) begin
            if (((curAddr & ADDR_W'((1 << s) - 1)) == '0) &&
                (remBytes >= (SIZE_W'(1) << s)))
              sizeCode = 2'(s);
          end
        end
      end
      default: sizeCode = SZ_BYTE;
    endcase
  end

  always_comb begin
    unitsAvail = remBytes >> unitShift;
    if (!useBurst)
      beats = 3'd1;
    else if (unitsAvail >= SIZE_W'(MAX_BURST))
      beats = 3'(MAX_BURST);
    else if (unitsAvail == '0)
      beats = 3'd1;
    else
      beats = unitsAvail[2:0];
  end

  assign burstLen  = 2'(beats - 3'd1);
  assign stepBytes = SIZE_W'(beats) << sizeCode;

endmodule

// File: rtl/dma_seq_dp.sv
module dma_seq_dp
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 16,
  parameter int BUS_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [2:0]        seqMode,
  input  logic [SIZE_W-1:0] cellBytes,
  input  logic [SIZE_W-1:0] blockBytes,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [1:0]        cmdSize,
  output logic [1:0]        cmdBurstLen,
  output logic              cfgBad,
  output logic              cellZero,
  output logic              lastCmd
);
  localparam logic [ADDR_W-1:0] BUS_AMASK = ADDR_W'(BUS_BYTES - 1);
  localparam logic [SIZE_W-1:0] BUS_SMASK = SIZE_W'(BUS_BYTES - 1);

  logic [ADDR_W-1:0] runAddr;
  logic [SIZE_W-1:0] remBytes;
  logic [2:0]        modeQ;
  logic              burstOkQ;
  logic [ADDR_W-1:0] baseAddr;
  logic              burstOkNext;
  logic              isInc;
  logic [SIZE_W-1:0] stepBytes;

  // a load in the same cycle as a start applies to that cell
  assign baseAddr = strobe.loadAddr ? startAddr : runAddr;
  assign isInc    = (modeQ == MODE_INC_B) || (modeQ == MODE_INC_H) ||
                    (modeQ == MODE_INC_AUTO);
  assign cellZero = (cellBytes == '0);

  always_comb begin
    case (seqMode)
      MODE_FIX_B, MODE_INC_B, MODE_INC_AUTO: cfgBad = 1'b0;
      MODE_FIX_H, MODE_INC_H: cfgBad = baseAddr[0] | cellBytes[0];
      MODE_FIX_W: cfgBad = (|baseAddr[1:0]) | (|cellBytes[1:0]);
      default:    cfgBad = 1'b1;
    endcase
  end

  assign burstOkNext = (seqMode == MODE_INC_AUTO) &&
                       ((baseAddr & BUS_AMASK) == '0) &&
                       ((cellBytes & BUS_SMASK) == '0) &&
                       ((blockBytes & BUS_SMASK) == '0);

  dma_seq_plan #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .BUS_BYTES(BUS_BYTES)
  ) u_plan (
    .curAddr  (runAddr),
    .remBytes (remBytes),
    .modeQ    (modeQ),
    .burstOk  (burstOkQ),
    .sizeCode (cmdSize),
    .burstLen (cmdBurstLen),
    .stepBytes(stepBytes)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runAddr  <= '0;
      remBytes <= '0;
      modeQ    <= MODE_FIX_B;
      burstOkQ <= 1'b0;
    end else begin
      if (strobe.loadAddr) runAddr <= startAddr;
      if (strobe.startCell) begin
        remBytes <= cellBytes;
        modeQ    <= seqMode;
        burstOkQ <= burstOkNext;
      end
      if (strobe.advance) begin
        remBytes <= remBytes - stepBytes;
        if (isInc) runAddr <= runAddr + ADDR_W'(stepBytes);
      end
    end
  end

  assign cmdAddr = runAddr;
  assign lastCmd = (stepBytes == remBytes);

  // accepted command never reaches past the end of the cell
  assert_step_fits_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |-> (stepBytes != '0) && (stepBytes <= remBytes));

  // bursts only in fixed word mode or eligible auto mode
  assert_burst_modes_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && cmdBurstLen != 2'd0) |->
      (modeQ == MODE_FIX_W) || (modeQ == MODE_INC_AUTO && burstOkQ));

  // fixed modes never move the running address while a cell runs
  assert_fixed_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !isInc) |=> (runAddr == $past(runAddr)));

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       addrLoad,
  input  logic       cellStart,
  input  logic       cmdReady,
  input  logic       cfgBad,
  input  logic       cellZero,
  input  logic       lastCmd,
  output seqStrobe_t strobe,
  output logic       cmdValid,
  output logic       busy,
  output logic       cellDone,
  output logic       alignErr
);
  typedef enum logic {ST_IDLE, ST_RUN} seqState_e;
  seqState_e state;
  logic      idle;

  assign idle = (state == ST_IDLE);
  assign strobe.loadAddr  = idle && addrLoad;
  assign strobe.startCell = idle && cellStart && !cfgBad && !cellZero;
  assign strobe.advance   = (state == ST_RUN) && cmdReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cellDone <= 1'b0;
      alignErr <= 1'b0;
    end else begin
      cellDone <= 1'b0;
      case (state)
        ST_IDLE: if (cellStart) begin
          if (cfgBad) begin
            alignErr <= 1'b1;
            cellDone <= 1'b1;
          end else if (cellZero) begin
            cellDone <= 1'b1;
          end else begin
            state <= ST_RUN;
          end
        end
        ST_RUN: if (cmdReady && lastCmd) begin
          state    <= ST_IDLE;
          cellDone <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmdValid = (state == ST_RUN);
  assign busy     = (state == ST_RUN);

  assert_valid_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> cmdValid);

  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    cellDone |-> !cmdValid);

  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rstN)
    alignErr |=> alignErr);

  assert_no_reject_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !$rose(alignErr));

endmodule

// File: rtl/dma_beat_seq.sv
module dma_beat_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 16,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              cellStart,
  input  logic [2:0]        seqMode,
  input  logic [SIZE_W-1:0] cellBytes,
  input  logic [SIZE_W-1:0] blockBytes,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [1:0]        cmdSize,
  output logic [1:0]        cmdBurstLen,
  output logic              cellDone,
  output logic              busy,
  output logic              alignErr
);
  localparam int BUS_BYTES = BUS_W / 8;

  seqStrobe_t strobe;
  logic       cfgBad;
  logic       cellZero;
  logic       lastCmd;

  dma_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .addrLoad (addrLoad),
    .cellStart(cellStart),
    .cmdReady (cmdReady),
    .cfgBad   (cfgBad),
    .cellZero (cellZero),
    .lastCmd  (lastCmd),
    .strobe   (strobe),
    .cmdValid (cmdValid),
    .busy     (busy),
    .cellDone (cellDone),
    .alignErr (alignErr)
  );

  dma_seq_dp #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .BUS_BYTES(BUS_BYTES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .startAddr  (startAddr),
    .seqMode    (seqMode),
    .cellBytes  (cellBytes),
    .blockBytes (blockBytes),
    .cmdAddr    (cmdAddr),
    .cmdSize    (cmdSize),
    .cmdBurstLen(cmdBurstLen),
    .cfgBad     (cfgBad),
    .cellZero   (cellZero),
    .lastCmd    (lastCmd)
  );

  assert_cmd_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=>
      ($stable(cmdAddr) && $stable(cmdSize) && $stable(cmdBurstLen)));

  assert_cmd_aligned_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> ((cmdAddr[2:0] & 3'((4'd1 << cmdSize) - 4'd1)) == 3'd0));

  assert_size_limit_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> ((32'd1 << cmdSize) <= 32'(BUS_BYTES)));

endmodule

// File: tb/dma_beat_seq_tb.sv
module dma_beat_seq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        addrLoad = 1'b0;
  logic [31:0] startAddr = '0;
  logic        cellStart = 1'b0;
  logic [2:0]  seqMode = '0;
  logic [15:0] cellBytes = '0;
  logic [15:0] blockBytes = '0;
  logic        cmdReady = 1'b0;
  logic        cmdValid, cellDone, busy, alignErr;
  logic [31:0] cmdAddr;
  logic [1:0]  cmdSize, cmdBurstLen;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dma_beat_seq u_dut (
    .clk(clk), .rstN(rstN), .addrLoad(addrLoad), .startAddr(startAddr),
    .cellStart(cellStart), .seqMode(seqMode), .cellBytes(cellBytes),
    .blockBytes(blockBytes), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdAddr(cmdAddr), .cmdSize(cmdSize), .cmdBurstLen(cmdBurstLen),
    .cellDone(cellDone), .busy(busy), .alignErr(alignErr)
  );

  typedef struct packed {
    logic        ld;
    logic [31:0] addr;
    logic [2:0]  mode;
    logic [15:0] nb;
    logic [15:0] blk;
    logic [7:0]  nCmd;
    logic [3:0]  req;
  } cell_t;

  typedef struct packed {
    logic [31:0] a;
    logic [1:0]  s;
    logic [1:0]  l;
  } expCmd_t;

  localparam int N_CELL = 8;
  localparam int N_EXP  = 19;

  localparam cell_t CELLS [N_CELL] = '{
    '{1'b1, 32'h1,   3'd5, 16'd8,  16'd64, 8'd4, 4'd6}, // R6 unaligned auto
    '{1'b0, 32'h0,   3'd3, 16'd2,  16'd0,  8'd2, 4'd8}, // R8 held addr, R5
    '{1'b1, 32'h100, 3'd2, 16'd24, 16'd0,  8'd2, 4'd4}, // R4 fixed word bursts
    '{1'b1, 32'h200, 3'd5, 16'd40, 16'd64, 8'd3, 4'd7}, // R7 auto bursts
    '{1'b0, 32'h0,   3'd4, 16'd4,  16'd0,  8'd2, 4'd5}, // R5 inc half
    '{1'b1, 32'h7,   3'd0, 16'd2,  16'd0,  8'd2, 4'd2}, // R2 fixed byte
    '{1'b1, 32'h302, 3'd1, 16'd4,  16'd0,  8'd2, 4'd3}, // R3 fixed half
    '{1'b1, 32'h400, 3'd5, 16'd8,  16'd6,  8'd2, 4'd6}  // R6 block unaligned
  };

  localparam expCmd_t EXPS [N_EXP] = '{
    '{32'h1, 2'd0, 2'd0}, '{32'h2, 2'd1, 2'd0}, '{32'h4, 2'd2, 2'd0}, '{32'h8, 2'd0, 2'd0},
    '{32'h9, 2'd0, 2'd0}, '{32'hA, 2'd0, 2'd0},
    '{32'h100, 2'd2, 2'd3}, '{32'h100, 2'd2, 2'd1},
    '{32'h200, 2'd2, 2'd3}, '{32'h210, 2'd2, 2'd3}, '{32'h220, 2'd2, 2'd1},
    '{32'h228, 2'd1, 2'd0}, '{32'h22A, 2'd1, 2'd0},
    '{32'h7, 2'd0, 2'd0}, '{32'h7, 2'd0, 2'd0},
    '{32'h302, 2'd1, 2'd0}, '{32'h302, 2'd1, 2'd0},
    '{32'h400, 2'd2, 2'd0}, '{32'h404, 2'd2, 2'd0}
  };

  function automatic string reqName(input logic [3:0] r);
    case (r)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic startCell(input bit ld, input logic [31:0] a, input logic [2:0] m,
                           input logic [15:0] nb, input logic [15:0] blk);
    @(negedge clk);
    addrLoad = ld; startAddr = a; seqMode = m; cellBytes = nb; blockBytes = blk;
    cellStart = 1'b1;
    @(negedge clk);
    cellStart = 1'b0; addrLoad = 1'b0;
  endtask

  // expects a command at the current negedge, optionally stalls, then accepts it
  task automatic takeCmd(input expCmd_t e, input string req, input bit stall);
    logic [31:0] a0;
    if (stall) begin
      a0 = cmdAddr;
      @(negedge clk);
      chk(cmdValid && cmdAddr == a0, "R9", "stalled cmd held", cmdAddr, a0);
    end
    chk(cmdValid, req, "cmdValid", 32'(cmdValid), 32'd1);
    chk(cmdAddr == e.a, req, "cmdAddr", cmdAddr, e.a);
    chk(cmdSize == e.s, req, "cmdSize", 32'(cmdSize), 32'(e.s));
    chk(cmdBurstLen == e.l, req, "cmdBurstLen", 32'(cmdBurstLen), 32'(e.l));
    cmdReady = 1'b1;
    @(negedge clk);
    cmdReady = 1'b0;
  endtask

  task automatic expectEnd(input string req);
    chk(cellDone && !cmdValid, "R10", {req, " cellDone after last"}, 32'(cellDone), 32'd1);
    @(negedge clk);
    chk(!cellDone && !busy, "R10", "cellDone one cycle", 32'(cellDone), 32'd0);
  endtask

  function automatic expCmd_t mk(input logic [31:0] a, input logic [1:0] s, input logic [1:0] l);
    mk.a = a; mk.s = s; mk.l = l;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int ei;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!cmdValid && !cellDone && !busy && !alignErr, "R1", "reset outputs",
        {28'd0, cmdValid, cellDone, busy, alignErr}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    ei = 0;
    for (int c = 0; c < N_CELL; c++) begin
      startCell(CELLS[c].ld, CELLS[c].addr, CELLS[c].mode, CELLS[c].nb, CELLS[c].blk);
      for (int k = 0; k < int'(CELLS[c].nCmd); k++) begin
        takeCmd(EXPS[ei], reqName(CELLS[c].req), k[0]);
        ei++;
      end
      expectEnd(reqName(CELLS[c].req));
    end

    // R11: load and start while busy are ignored
    startCell(1'b1, 32'h500, 3'd3, 16'd2, 16'd0);
    addrLoad = 1'b1; startAddr = 32'h900; cellStart = 1'b1; cellBytes = 16'd0;
    @(negedge clk);
    addrLoad = 1'b0; cellStart = 1'b0;
    chk(cmdAddr == 32'h500 && !cellDone, "R11", "load during busy", cmdAddr, 32'h500);
    takeCmd(mk(32'h500, 2'd0, 2'd0), "R11", 1'b0);
    takeCmd(mk(32'h501, 2'd0, 2'd0), "R11", 1'b0);
    expectEnd("R11");
    startCell(1'b0, 32'h0, 3'd3, 16'd1, 16'd0);
    takeCmd(mk(32'h502, 2'd0, 2'd0), "R11", 1'b0);
    expectEnd("R11");

    // R10: zero-length cell
    startCell(1'b0, 32'h0, 3'd3, 16'd0, 16'd0);
    chk(cellDone && !cmdValid && !alignErr, "R10", "zero cell done",
        {30'd0, cellDone, cmdValid}, 32'd2);
    @(negedge clk);
    chk(!cellDone, "R10", "zero cell pulse", 32'(cellDone), 32'd0);
    startCell(1'b0, 32'h0, 3'd3, 16'd1, 16'd0);
    takeCmd(mk(32'h503, 2'd0, 2'd0), "R8", 1'b0);
    expectEnd("R8");

    // R3: misaligned fixed word with a same-cycle load (R8)
    startCell(1'b1, 32'h102, 3'd2, 16'd4, 16'd0);
    chk(cellDone && !cmdValid && alignErr, "R3", "misaligned word rejected",
        {29'd0, cellDone, cmdValid, alignErr}, 32'd5);
    @(negedge clk);
    chk(!cmdValid && alignErr, "R12", "err held", 32'(alignErr), 32'd1);

    // R12: good cell leaves error set
    startCell(1'b1, 32'h600, 3'd0, 16'd1, 16'd0);
    takeCmd(mk(32'h600, 2'd0, 2'd0), "R2", 1'b0);
    expectEnd("R2");
    chk(alignErr, "R12", "err survives good cell", 32'(alignErr), 32'd1);

    // R3: unused mode code and odd half-word length
    startCell(1'b1, 32'h0, 3'd6, 16'd4, 16'd0);
    chk(cellDone && !cmdValid, "R3", "mode 6 rejected", 32'(cellDone), 32'd1);
    startCell(1'b1, 32'h10, 3'd4, 16'd3, 16'd0);
    chk(cellDone && !cmdValid, "R3", "odd half length rejected", 32'(cellDone), 32'd1);
    @(negedge clk);
    chk(!cmdValid && !busy, "R3", "no command after reject", 32'(cmdValid), 32'd0);

    // R1/R12: reset clears error
    rstN = 1'b0;
    @(negedge clk);
    chk(!alignErr && !busy, "R12", "reset clears err", 32'(alignErr), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule